// File: doc/BRIEF.md
# CAN Frame Bit Serializer

This block converts one message descriptor into the unstuffed bit sequence of a CAN data frame or remote frame, in either the 11-bit or the 29-bit identifier format. A `start_i` pulse while idle captures the identifier, format select, remote flag, length code and payload. The block then presents the frame one bit at a time. Each `strobe_i` pulse, issued once per bit time by the bit-timing logic, advances it to the next bit.

With each bit the block also gives a field tag and a flag that marks the bits to which a downstream stuffing stage must apply its rule. The 15-bit CRC is built while the header and payload bits go out, and it is then sent directly after them. Stuff insertion, bus sampling and arbitration belong to neighbouring logic.

Top module: `can_frame_ser`

## Requirements
- R1: Out of reset and between frames, `field_o` is 0 (idle), `bit_o` is 1 and `stuff_o` is 0. A `start_i` pulse while idle makes the next cycle show the Start-of-Frame bit, which is 0, with tag 1. Strobes while idle have no effect.
- R2: With `ext_i`=0 the frame is: SOF, then `id_i[28:18]` MSB first (tag 2), then the remote bit (tag 2), then 0, 0 and the four length bits MSB first (tag 3).
- R3: With `ext_i`=1 the frame is: SOF, then `id_i[28:18]`, then 1, 1, then `id_i[17:0]` MSB first, then the remote bit (all tag 2), then 0, 0 and the four length bits (tag 3).
- R4: The remote bit is `rtr_i`: 0 for a data frame and 1 for a remote frame. A remote frame has no payload bits, whatever its length code.
- R5: A data frame carries min(`dlc_i`, 8) payload bytes with tag 4. Byte k is `data_i[8k+7:8k]`; byte 0 goes first and each byte is sent MSB first.
- R6: Fifteen CRC bits follow, MSB first, with tag 5. They use generator 0x4599 (x^15+x^14+x^10+x^8+x^7+x^4+x^3+1), start from zero and cover SOF through the last payload bit.
- R7: The tail is one recessive CRC delimiter (tag 6), two recessive acknowledge bits (tag 7) and seven recessive End-of-Frame bits (tag 8). A strobe on the last of these returns the block to idle.
- R8: `stuff_o` is 1 from SOF through the last CRC bit and 0 everywhere else.
- R9: The outputs change only on a cycle that follows a strobe. A `start_i` pulse during a frame is ignored.
- R10: The field tag codes are: 0 idle, 1 SOF, 2 arbitration, 3 control, 4 data, 5 CRC, 6 CRC delimiter, 7 acknowledge, 8 End-of-Frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture the descriptor and begin a frame (idle only) |
| strobe_i | input | 1 | Bit-time strobe; advances one bit |
| ext_i | input | 1 | 1 selects the 29-bit identifier format |
| rtr_i | input | 1 | 1 requests a remote frame |
| id_i | input | 29 | Identifier; the standard format uses bits 28:18 |
| dlc_i | input | 4 | Length code |
| data_i | input | 64 | Payload; byte k is in bits 8k+7:8k |
| bit_o | output | 1 | Current frame bit (0 dominant) |
| field_o | output | 4 | Field tag of the current bit |
| stuff_o | output | 1 | Current bit falls under the stuffing rule |

## Verification
The bench goes after the following corner cases, with these failure symptoms:
- **Header slot order.** Standard and extended headers are interleaved at random. A swap of the SRR and IDE placement, or a misplaced split of the 18 low identifier bits, shows up as a wrong bit at a known index.
- **Payload length edges.** Length codes 0, 8 and 9 to 15 are checked. A design that takes the code literally, or that sends payload in remote frames, shifts the CRC and every later tag.
- **CRC.** The CRC is recomputed independently, so a wrong polynomial, seed or coverage range shows as a CRC bit mismatch.
- **Strobe gaps.** Random gaps between strobes, with stray start pulses during a frame, expose any design that advances without a strobe or restarts in mid-frame.

// File: rtl/can_ser_pkg.sv
package can_ser_pkg;
  localparam int unsigned BASE_W  = 11;
  localparam int unsigned ID_W    = 29;
  localparam int unsigned DLC_W   = 4;
  localparam int unsigned CRC_W   = 15;
  localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;
  localparam int unsigned EOF_LEN = 7;
  localparam int unsigned HDR_STD = 19;  // SOF+11+RTR+6
  localparam int unsigned HDR_EXT = 39;  // SOF+11+2+18+RTR+6

  typedef enum logic [3:0] {
    FLD_IDLE = 4'd0, FLD_SOF = 4'd1, FLD_ARB = 4'd2, FLD_CTRL = 4'd3,
    FLD_DATA = 4'd4, FLD_CRC = 4'd5, FLD_CDEL = 4'd6, FLD_ACK = 4'd7,
    FLD_EOF = 4'd8
  } fld_e;

  typedef enum logic [1:0] {ST_IDLE, ST_BODY, ST_CRC, ST_TAIL} st_e;
endpackage

// File: rtl/can_hdr_pack.sv
module can_hdr_pack
  import can_ser_pkg::*;
(
  input  logic                ext_i,
  input  logic                rtr_i,
  input  logic [ID_W-1:0]     id_i,
  input  logic [DLC_W-1:0]    dlc_i,
  output logic [HDR_EXT-1:0]  hdr_o,
  output logic [5:0]          hdr_len_o
);
  localparam int unsigned PAD = HDR_EXT - HDR_STD;

  always_comb begin
    if (ext_i) begin
      // SRR and IDE recessive sit where RTR and IDE sit in the short form
      hdr_o     = {1'b0, id_i[ID_W-1 -: BASE_W], 1'b1, 1'b1,
                   id_i[ID_W-BASE_W-1:0], rtr_i, 2'b00, dlc_i};
      hdr_len_o = 6'(HDR_EXT);
    end else begin
      hdr_o     = {1'b0, id_i[ID_W-1 -: BASE_W], rtr_i, 2'b00, dlc_i,
                   {PAD{1'b0}}};
      hdr_len_o = 6'(HDR_STD);
    end
  end
endmodule

// File: rtl/can_crc15.sv
module can_crc15 #(
  parameter int unsigned       W    = 15,
  parameter logic [W-1:0]      POLY = 15'h4599
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic upd_i,
  input  logic shift_i,
  input  logic bit_i,
  output logic msb_o
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb    = bit_i ^ crc_q[W-1];
  assign msb_o = crc_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clr_i)   crc_q <= '0;
    else if (upd_i)   crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    else if (shift_i) crc_q <= {crc_q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/can_frame_ser.sv
module can_frame_ser
  import can_ser_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    strobe_i,
  input  logic                    ext_i,
  input  logic                    rtr_i,
  input  logic [ID_W-1:0]         id_i,
  input  logic [DLC_W-1:0]        dlc_i,
  input  logic [8*MAX_BYTES-1:0]  data_i,
  output logic                    bit_o,
  output logic [3:0]              field_o,
  output logic                    stuff_o
);
  localparam int unsigned DATA_W   = 8 * MAX_BYTES;
  localparam int unsigned SR_W     = HDR_EXT + DATA_W;
  localparam int unsigned CNT_W    = $clog2(SR_W + 1);
  localparam int unsigned NB_W     = $clog2(MAX_BYTES + 1);
  localparam int unsigned TAIL_LEN = 3 + EOF_LEN;
  localparam int unsigned ARB_STD  = 1 + BASE_W + 1;
  localparam int unsigned ARB_EXT  = 1 + BASE_W + 2 + (ID_W - BASE_W) + 1;

  st_e               st_q;
  logic [CNT_W-1:0]  cnt_q, len_q, arb_end;
  logic [5:0]        hlen_q;
  logic              ext_q;
  logic [SR_W-1:0]   sr_q, sr_load;
  logic [HDR_EXT-1:0] hdr;
  logic [5:0]        hdr_len;
  logic [DATA_W-1:0] data_seq;
  logic [NB_W-1:0]   nbytes;
  logic [CNT_W-1:0]  body_len;
  logic              crc_msb, go;

  can_hdr_pack u_hdr (
    .ext_i(ext_i), .rtr_i(rtr_i), .id_i(id_i), .dlc_i(dlc_i),
    .hdr_o(hdr), .hdr_len_o(hdr_len)
  );

  // byte 0 leads on the wire
  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
    assign data_seq[DATA_W-1-8*b -: 8] = data_i[8*b +: 8];
  end

  assign nbytes   = rtr_i ? '0 :
                    (32'(dlc_i) >= MAX_BYTES) ? NB_W'(MAX_BYTES) : NB_W'(dlc_i);
  assign body_len = CNT_W'(hdr_len) + CNT_W'({nbytes, 3'b000});
  assign sr_load  = ext_i ? {hdr, data_seq}
                          : {hdr[HDR_EXT-1 -: HDR_STD], data_seq,
                             {(HDR_EXT-HDR_STD){1'b0}}};
  assign go       = (st_q == ST_IDLE) && start_i;
  assign arb_end  = ext_q ? CNT_W'(ARB_EXT) : CNT_W'(ARB_STD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      len_q  <= '0;
      hlen_q <= '0;
      ext_q  <= 1'b0;
      sr_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_BODY;
          cnt_q  <= '0;
          len_q  <= body_len;
          hlen_q <= hdr_len;
          ext_q  <= ext_i;
          sr_q   <= sr_load;
        end
        ST_BODY: if (strobe_i) begin
          sr_q <= {sr_q[SR_W-2:0], 1'b0};
          if (cnt_q == len_q - 1'b1) begin
            st_q  <= ST_CRC;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_CRC: if (strobe_i) begin
          if (cnt_q == CNT_W'(CRC_W - 1)) begin
            st_q  <= ST_TAIL;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_TAIL: if (strobe_i) begin
          if (cnt_q == CNT_W'(TAIL_LEN - 1)) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  can_crc15 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(go),
    .upd_i((st_q == ST_BODY) && strobe_i),
    .shift_i((st_q == ST_CRC) && strobe_i),
    .bit_i(sr_q[SR_W-1]), .msb_o(crc_msb)
  );

  always_comb begin
    bit_o   = 1'b1;
    field_o = FLD_IDLE;
    stuff_o = 1'b0;
    unique case (st_q)
      ST_BODY: begin
        bit_o   = sr_q[SR_W-1];
        stuff_o = 1'b1;
        if (cnt_q == '0)                   field_o = FLD_SOF;
        else if (cnt_q < arb_end)          field_o = FLD_ARB;
        else if (cnt_q < CNT_W'(hlen_q))   field_o = FLD_CTRL;
        else                               field_o = FLD_DATA;
      end
      ST_CRC: begin
        bit_o   = crc_msb;
        stuff_o = 1'b1;
        field_o = FLD_CRC;
      end
      ST_TAIL: begin
        if (cnt_q == '0)                   field_o = FLD_CDEL;
        else if (cnt_q < CNT_W'(3))        field_o = FLD_ACK;
        else                               field_o = FLD_EOF;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/can_frame_ser_chk.sv
module can_frame_ser_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       strobe_i,
  input logic       bit_o,
  input logic [3:0] field_o,
  input logic       stuff_o
);
  p_start_sof_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_o == 4'd0 && start_i) |=> (field_o == 4'd1 && bit_o == 1'b0));

  p_sof_to_arb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_o == 4'd1 && strobe_i) |=> field_o == 4'd2);

  p_crc_exit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_o == 4'd5 && strobe_i) |=> (field_o == 4'd5 || field_o == 4'd6));

  p_tail_recessive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_o >= 4'd6) |-> bit_o);

  p_eof_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_o == 4'd8 && strobe_i) |=> (field_o == 4'd8 || field_o == 4'd0));

  p_stuff_span_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuff_o == (field_o >= 4'd1 && field_o <= 4'd5));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_o != 4'd0 && !strobe_i) |=> ($stable(field_o) && $stable(bit_o)));
endmodule

bind can_frame_ser can_frame_ser_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .strobe_i(strobe_i),
  .bit_o(bit_o), .field_o(field_o), .stuff_o(stuff_o)
);

// File: tb/tb_can_frame_ser.sv
module tb_can_frame_ser;
  import can_ser_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, strobe_i = 1'b0;
  logic        ext_i = 1'b0, rtr_i = 1'b0;
  logic [28:0] id_i = '0;
  logic [3:0]  dlc_i = '0;
  logic [63:0] data_i = '0;
  logic        bit_o, stuff_o;
  logic [3:0]  field_o;

  int n_chk = 0, n_bad = 0;
  int seed = 32'h5eed_c0de;
  logic       eb [0:199];
  logic [3:0] ef [0:199];
  int         elen;

  always #10 clk = ~clk;

  can_frame_ser dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .strobe_i(strobe_i),
    .ext_i(ext_i), .rtr_i(rtr_i), .id_i(id_i), .dlc_i(dlc_i), .data_i(data_i),
    .bit_o(bit_o), .field_o(field_o), .stuff_o(stuff_o)
  );

  function automatic void push(logic b, logic [3:0] f);
    eb[elen] = b; ef[elen] = f; elen++;
  endfunction

  function automatic void build(logic x, logic r, logic [28:0] id,
                                logic [3:0] dlc, logic [63:0] d);
    int nb;
    logic [14:0] crc;
    elen = 0;
    push(1'b0, FLD_SOF);
    for (int i = 28; i >= 18; i--) push(id[i], FLD_ARB);
    if (x) begin
      push(1'b1, FLD_ARB); push(1'b1, FLD_ARB);
      for (int i = 17; i >= 0; i--) push(id[i], FLD_ARB);
    end
    push(r, FLD_ARB);
    push(1'b0, FLD_CTRL); push(1'b0, FLD_CTRL);
    for (int i = 3; i >= 0; i--) push(dlc[i], FLD_CTRL);
    nb = r ? 0 : (dlc > 8 ? 8 : int'(dlc));
    for (int k = 0; k < nb; k++)
      for (int i = 7; i >= 0; i--) push(d[8*k+i], FLD_DATA);
    crc = '0;
    for (int j = 0; j < elen; j++) begin
      logic fbk;
      fbk = eb[j] ^ crc[14];
      crc = {crc[13:0], 1'b0};
      if (fbk) crc = crc ^ 15'h4599;
    end
    for (int i = 14; i >= 0; i--) push(crc[i], FLD_CRC);
    push(1'b1, FLD_CDEL);
    push(1'b1, FLD_ACK); push(1'b1, FLD_ACK);
    for (int i = 0; i < 7; i++) push(1'b1, FLD_EOF);
  endfunction

  function automatic string tag_of(logic [3:0] f, logic x);
    case (f)
      FLD_SOF:  return "R1";
      FLD_ARB:  return x ? "R3" : "R2";
      FLD_CTRL: return "R4";
      FLD_DATA: return "R5";
      FLD_CRC:  return "R6";
      default:  return "R7";
    endcase
  endfunction

  task automatic cmp(string rq, logic b, logic [3:0] f, logic s);
    n_chk++;
    if (bit_o !== b || field_o !== f || stuff_o !== s) begin
      n_bad++;
      $display("FAIL %s: got bit=%0b fld=%0d stuff=%0b exp bit=%0b fld=%0d stuff=%0b",
               rq, bit_o, field_o, stuff_o, b, f, s);
    end
  endtask

  task automatic run(logic x, logic r, logic [28:0] id, logic [3:0] dlc,
                     logic [63:0] d, bit gaps);
    build(x, r, id, dlc, d);
    @(negedge clk);
    ext_i = x; rtr_i = r; id_i = id; dlc_i = dlc; data_i = d; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < elen; i++) begin
      cmp(tag_of(ef[i], x), eb[i], ef[i], ef[i] <= FLD_CRC); // R10 R8 tags/flag
      if (gaps && ($urandom(seed) % 4 == 0)) begin
        start_i = ($urandom(seed) % 2 == 0);   // stray start mid-frame: R9
        ext_i = ~x; id_i = ~id;
        @(negedge clk);
        start_i = 1'b0;
        cmp("R9", eb[i], ef[i], ef[i] <= FLD_CRC);
        ext_i = x; id_i = id;
      end
      strobe_i = 1'b1;
      @(negedge clk);
      strobe_i = 1'b0;
    end
    cmp("R7", 1'b1, FLD_IDLE, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1", 1'b1, FLD_IDLE, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    strobe_i = 1'b1;                     // strobes while idle do nothing: R1
    repeat (3) @(negedge clk);
    strobe_i = 1'b0;
    cmp("R1", 1'b1, FLD_IDLE, 1'b0);
    run(1'b0, 1'b0, 29'h1FFFFFFF, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0); // R2 R5
    run(1'b1, 1'b1, 29'h0AAAAAAA, 4'd15, 64'h0123_4567_89AB_CDEF, 1'b1); // R3 R4
    run(1'b0, 1'b0, 29'h00040000, 4'd0, 64'h0, 1'b1);                  // R5
    run(1'b0, 1'b0, 29'h155AA000, 4'd12, 64'hDEAD_BEEF_CAFE_F00D, 1'b1); // R5
    run(1'b1, 1'b0, 29'h00000000, 4'd1, 64'h80, 1'b0);                  // R3 R6
    run(1'b0, 1'b1, 29'h0FFC0000, 4'd4, 64'h1234, 1'b1);                // R4
    for (int n = 0; n < 30; n++) begin
      logic [63:0] d;
      d = {$urandom(seed), $urandom(seed)};
      run(1'($urandom(seed)), ($urandom(seed) % 4 == 0), 29'($urandom(seed)),
          4'($urandom(seed)), d, 1'b1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule